// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the slave side of a two-wire serial bus for a byte-wide memory of 16K locations. It watches oversampled clock and data lines on a fast system clock and pulls the data line low through an open-drain enable. It recognises bus start and stop conditions and checks the device byte against a fixed four-bit code. A write transfer carries a two-byte word address followed by data bytes. Each data byte leaves the block as a one-cycle write strobe to an external page buffer, and the address steps forward after every byte. A read transfer streams bytes from the external array, starting at the current address, for as long as the master keeps acknowledging.

A stop that ends a transfer carrying data raises a commit pulse, which starts the array's internal programming. While the array reports that it is busy, the engine does not acknowledge its device byte and takes nothing from the bus. The address register survives a repeated start. So a master sets the address with a write header, issues a repeated start, and reads from that address.

Top module: `i2cs_mem_slave`

## Requirements
- R1: After reset, sdaOe is 0 (line released), memWrEn is 0 and wrCommit is 0.
- R2: The first byte after a START is acknowledged when its bits 7:4 equal 1010, whatever bits 3:1 hold. Bit 0 = 1 selects a read and bit 0 = 0 selects a write. Any other upper nibble is not acknowledged, and the engine then ignores the bus until the next START.
- R3: For every byte it accepts, the engine holds SDA low (sdaOe = 1) through the whole ninth SCL high phase. Apart from a START or STOP, sdaOe changes only while the synchronised SCL is low.
- R4: In a write, the two bytes after the device byte form the word address: the first supplies bits 13:8 from its bits 5:0, and its bits 7:6 are ignored. The second supplies bits 7:0. Each following data byte gives one memWrEn pulse of a single cycle, with memAddr holding the word address and memWrData holding the byte.
- R5: Successive data bytes within one write are strobed at addresses that rise by one per byte.
- R6: One cycle after a STOP, wrCommit pulses for one cycle if at least one data byte was strobed since the previous STOP. A STOP with no data byte gives no pulse.
- R7: A read sends memRdData for the current address, MSB first, and then increments the address. The address wraps from 16383 to 0. It starts at the address that the last write header or the last transfer left behind.
- R8: When the master does not acknowledge a read byte, the engine releases SDA and sends nothing more until the next START.
- R9: While wrBusy is 1 at the end of the device byte, the engine does not acknowledge, drives no memWrEn for the bytes that follow, and gives no commit.
- R10: A START in the middle of a byte discards the partial byte, produces no write, leaves the address unchanged and restarts device-byte matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the SCL rate |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls the data line low, 0 releases it |
| wrBusy | input | 1 | Array is running an internal write cycle |
| memAddr | output | 14 | Current word address |
| memWrEn | output | 1 | One-cycle strobe for a received data byte |
| memWrData | output | 8 | Received data byte, valid with memWrEn |
| memRdData | input | 8 | Array data at memAddr |
| wrCommit | output | 1 | One-cycle pulse after a STOP that closed a write carrying data |

## Verification
The checks on line behaviour assume that the master changes SDA only while SCL is low, except when it makes a START or STOP. They also assume that the master never tries to make a START while the slave is holding SDA low. Every bench transaction places SDA changes in the middle of the low phase, and each high and low phase lasts twenty system clocks. The bench only issues a repeated start after an acknowledge phase has ended or in the middle of a master-driven byte. The assertions also take wrBusy to change only between transactions, and the bench sets it only while the bus is idle.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_AHI, PH_ALO, PH_WDAT, PH_READ, PH_WAIT
  } phase_e;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic incAddr;
    logic loadTx;
    logic txOff;
  } dpCtl_t;
endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath #(
  parameter int ADDR_W = 14,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  i2cs_pkg::dpCtl_t  ctl,
  input  logic [7:0]        memRdData,
  output logic              sclHigh,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic [3:0]        bitCnt,
  output logic [7:0]        rxByte,
  output logic              mAck,
  output logic [ADDR_W-1:0] addr,
  output logic              txLow
);
  localparam int HI_W = ADDR_W - 8;

  logic [SYNC_N-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclP, sdaP;
  logic [7:0] txSh;
  logic txOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclP  <= 1'b1;
      sdaP  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_N-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_N-2:0], sdaIn};
      sclP  <= sclS;
      sdaP  <= sdaS;
    end
  end

  assign sclS     = sclSh[SYNC_N-1];
  assign sdaS     = sdaSh[SYNC_N-1];
  assign sclHigh  = sclS;
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
      mAck   <= 1'b0;
    end else if (startDet) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      if (bitCnt < 4'd8) rxByte <= {rxByte[6:0], sdaS};
      if (bitCnt == 4'd8) mAck <= ~sdaS;
      if (bitCnt != 4'd9) bitCnt <= bitCnt + 4'd1;
    end else if (sclFall && bitCnt == 4'd9) begin
      bitCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
    end else if (ctl.loadHi) begin
      addr[ADDR_W-1:8] <= rxByte[HI_W-1:0];
    end else if (ctl.loadLo) begin
      addr[7:0] <= rxByte;
    end else if (ctl.incAddr) begin
      addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '1;
      txOn <= 1'b0;
    end else if (ctl.txOff) begin
      txOn <= 1'b0;
    end else if (ctl.loadTx) begin
      txSh <= memRdData;
      txOn <= 1'b1;
    end else if (txOn && sclFall && bitCnt != 4'd0 && bitCnt < 4'd8) begin
      txSh <= {txSh[6:0], 1'b1};
    end
  end

  assign txLow = txOn & ~txSh[7];
endmodule

// File: rtl/i2cs_control.sv
module i2cs_control #(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclFall,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic [3:0]       bitCnt,
  input  logic [7:0]       rxByte,
  input  logic             mAck,
  input  logic             wrBusy,
  output i2cs_pkg::dpCtl_t ctl,
  output logic             ackOe,
  output logic             memWrEn,
  output logic             wrCommit
);
  import i2cs_pkg::*;

  phase_e phase;
  logic firstRd, dirty;
  logic byteEnd, ackEnd, devHit, busEvt;

  assign busEvt  = startDet | stopDet;
  assign byteEnd = sclFall && bitCnt == 4'd8 && !busEvt;
  assign ackEnd  = sclFall && bitCnt == 4'd9 && !busEvt;
  assign devHit  = rxByte[7:4] == DEV_CODE && !wrBusy;
  assign memWrEn = byteEnd && phase == PH_WDAT;

  always_comb begin
    ctl = '0;
    if (busEvt) begin
      ctl.txOff = 1'b1;
    end else begin
      if (byteEnd) begin
        case (phase)
          PH_AHI:  ctl.loadHi = 1'b1;
          PH_ALO:  ctl.loadLo = 1'b1;
          PH_WDAT: ctl.incAddr = 1'b1;
          PH_READ: begin
            ctl.incAddr = 1'b1;
            ctl.txOff   = 1'b1;
          end
          default: ;
        endcase
      end
      if (ackEnd && phase == PH_READ && (firstRd || mAck)) ctl.loadTx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      ackOe    <= 1'b0;
      firstRd  <= 1'b0;
      dirty    <= 1'b0;
      wrCommit <= 1'b0;
    end else begin
      wrCommit <= 1'b0;
      if (startDet) begin
        phase   <= PH_DEV;
        ackOe   <= 1'b0;
        firstRd <= 1'b0;
      end else if (stopDet) begin
        phase    <= PH_IDLE;
        ackOe    <= 1'b0;
        wrCommit <= dirty;
        dirty    <= 1'b0;
      end else if (byteEnd) begin
        case (phase)
          PH_DEV: begin
            if (devHit) begin
              ackOe   <= 1'b1;
              firstRd <= rxByte[0];
              phase   <= rxByte[0] ? PH_READ : PH_AHI;
            end else begin
              phase <= PH_IDLE;
            end
          end
          PH_AHI: begin
            ackOe <= 1'b1;
            phase <= PH_ALO;
          end
          PH_ALO: begin
            ackOe <= 1'b1;
            phase <= PH_WDAT;
          end
          PH_WDAT: begin
            ackOe <= 1'b1;
            dirty <= 1'b1;
          end
          default: ;
        endcase
      end else if (ackEnd) begin
        ackOe <= 1'b0;
        if (phase == PH_READ) begin
          firstRd <= 1'b0;
          if (!(firstRd || mAck)) phase <= PH_WAIT;
        end
      end
    end
  end
endmodule

// File: rtl/i2cs_mem_slave.sv
module i2cs_mem_slave #(
  parameter int         ADDR_W   = 14,
  parameter int         SYNC_N   = 2,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              wrBusy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  output logic              wrCommit
);
  i2cs_pkg::dpCtl_t ctl;
  logic sclHigh, sclRise, sclFall, startDet, stopDet, mAck, txLow, ackOe;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;

  i2cs_datapath #(.ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .memRdData(memRdData), .sclHigh(sclHigh), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .bitCnt(bitCnt), .rxByte(rxByte), .mAck(mAck), .addr(memAddr),
    .txLow(txLow)
  );

  i2cs_control #(.DEV_CODE(DEV_CODE)) uCtl (
    .clk(clk), .rstN(rstN), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .bitCnt(bitCnt), .rxByte(rxByte), .mAck(mAck),
    .wrBusy(wrBusy), .ctl(ctl), .ackOe(ackOe), .memWrEn(memWrEn),
    .wrCommit(wrCommit)
  );

  assign sdaOe     = ackOe | txLow;
  assign memWrData = rxByte;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rstN,
  input logic sclHigh,
  input logic startDet,
  input logic stopDet,
  input logic sdaOe,
  input logic memWrEn,
  input logic wrCommit
);
  // R3: output only moves while the clock line is low
  a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclHigh && $past(sclHigh) && !$past(startDet) && !$past(stopDet)) |-> $stable(sdaOe));

  // R4: a write strobe lasts one cycle
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R6: commit follows a stop
  a_r6_commit_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> $past(stopDet));

  // R6: commit is a single pulse
  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  // R10: a start leaves the data line released
  a_r10_start_release: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);
endmodule

bind i2cs_mem_slave i2cs_checker uChk (
  .clk(clk), .rstN(rstN), .sclHigh(sclHigh), .startDet(startDet),
  .stopDet(stopDet), .sdaOe(sdaOe), .memWrEn(memWrEn), .wrCommit(wrCommit)
);

// File: tb/tb_i2cs_mem_slave.sv
module tb_i2cs_mem_slave;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, sclM, sdaM, wrBusy;
  logic sdaOe, memWrEn, wrCommit;
  logic [13:0] memAddr;
  logic [7:0] memWrData, memRdData;
  wire sdaBus = sdaM & ~sdaOe;

  function automatic logic [7:0] rdModel(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
  endfunction

  assign memRdData = rdModel(memAddr);

  i2cs_mem_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .wrBusy(wrBusy), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData), .wrCommit(wrCommit)
  );

  int checks = 0, fails = 0, commits = 0;
  bit done = 0;
  logic [21:0] wq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: compares every write strobe with the queue
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      checks++;
      if (wq.size() == 0) begin
        fails++;
        $display("FAIL R4 R9 unexpected write actual=%h expected=none", {memAddr, memWrData});
      end else begin
        logic [21:0] e;
        e = wq.pop_front();
        if ({memAddr, memWrData} !== e) begin
          fails++;
          $display("FAIL R4 R5 write actual=%h expected=%h", {memAddr, memWrData}, e);
        end
      end
    end
    if (rstN && wrCommit) commits++;
  end

  task automatic bStart();
    sdaM = 1'b1; waitc(10);
    sclM = 1'b1; waitc(10);
    sdaM = 1'b0; waitc(10);
    sclM = 1'b0; waitc(10);
  endtask

  task automatic bStop();
    sdaM = 1'b0; waitc(10);
    sclM = 1'b1; waitc(10);
    sdaM = 1'b1; waitc(20);
  endtask

  task automatic bBit(input logic b, output logic sEarly, output logic sLate);
    sdaM = b; waitc(10);
    sclM = 1'b1; waitc(2);
    sEarly = sdaBus; waitc(8);
    sLate = sdaBus; waitc(10);
    sclM = 1'b0; waitc(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic e, l;
    for (int i = 7; i >= 0; i--) bBit(b[i], e, l);
    bBit(1'b1, e, l);
    ack = !e && !l;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    logic e, l;
    for (int i = 7; i >= 0; i--) begin
      bBit(1'b1, e, l);
      b[i] = l;
    end
    bBit(!giveAck, e, l);
  endtask

  task automatic pushWr(input logic [13:0] a, input logic [7:0] d);
    wq.push_back({a, d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack, e, l;
    logic [7:0] rb;
    int c0;
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1; wrBusy = 1'b0;
    waitc(5);
    chk("R1 sdaOe in reset", sdaOe, 0);
    rstN = 1'b1;
    waitc(10);
    chk("R1 sdaOe after reset", sdaOe, 0);
    chk("R1 memWrEn after reset", memWrEn, 0);
    chk("R1 wrCommit after reset", wrCommit, 0);

    // write three bytes, upper address bits set but ignored
    c0 = commits;
    bStart();
    sendByte(8'hA0, ack); chk("R2 write device ack", ack, 1);
    sendByte(8'hC1, ack); chk("R3 addr hi ack", ack, 1);
    sendByte(8'h23, ack); chk("R3 addr lo ack", ack, 1);
    pushWr(14'h0123, 8'h11); sendByte(8'h11, ack); chk("R4 data ack", ack, 1);
    pushWr(14'h0124, 8'h22); sendByte(8'h22, ack); chk("R5 data ack", ack, 1);
    pushWr(14'h0125, 8'h33); sendByte(8'h33, ack); chk("R5 data ack 3", ack, 1);
    bStop();
    chk("R6 commit after data", commits - c0, 1);
    chk("R5 queue drained", wq.size(), 0);

    // current address read after write
    bStart();
    sendByte(8'hA1, ack); chk("R2 read device ack", ack, 1);
    recvByte(1'b0, rb); chk("R7 current read", rb, rdModel(14'h0126));
    bStop();

    // random read with wrap, don't-care bits set
    c0 = commits;
    bStart();
    sendByte(8'hAE, ack); chk("R2 dont-care bits ack", ack, 1);
    sendByte(8'h3F, ack); sendByte(8'hFE, ack);
    bStart();
    sendByte(8'hAF, ack); chk("R2 read after repeated start", ack, 1);
    recvByte(1'b1, rb); chk("R7 read 3FFE", rb, rdModel(14'h3FFE));
    recvByte(1'b1, rb); chk("R7 read 3FFF", rb, rdModel(14'h3FFF));
    recvByte(1'b0, rb); chk("R7 wrap to 0", rb, rdModel(14'h0000));
    recvByte(1'b0, rb); chk("R8 released after nack", rb, 8'hFF);
    bStop();
    chk("R6 no commit without data", commits - c0, 0);

    bStart();
    sendByte(8'hA1, ack);
    recvByte(1'b0, rb); chk("R8 address held after nack", rb, rdModel(14'h0001));
    bStop();

    // non-matching codes
    bStart();
    sendByte(8'h50, ack); chk("R2 code 0101 nack", ack, 0);
    sendByte(8'h00, ack); chk("R2 ignored after mismatch", ack, 0);
    bStop();
    bStart();
    sendByte(8'hE0, ack); chk("R2 code 1110 nack", ack, 0);
    bStop();

    // busy array
    c0 = commits;
    wrBusy = 1'b1;
    bStart();
    sendByte(8'hA0, ack); chk("R9 busy nack", ack, 0);
    sendByte(8'h00, ack); chk("R9 busy byte ignored", ack, 0);
    sendByte(8'h10, ack);
    sendByte(8'h55, ack);
    bStop();
    chk("R9 busy no commit", commits - c0, 0);
    wrBusy = 1'b0;
    bStart();
    sendByte(8'hA0, ack); chk("R9 responds when idle", ack, 1);
    bStop();

    // repeated start in the middle of a data byte
    c0 = commits;
    bStart();
    sendByte(8'hA0, ack); sendByte(8'h00, ack); sendByte(8'h40, ack);
    bBit(1'b1, e, l); bBit(1'b0, e, l); bBit(1'b1, e, l); bBit(1'b0, e, l);
    bStart();
    sendByte(8'hA1, ack); chk("R10 rematch after abort", ack, 1);
    recvByte(1'b0, rb); chk("R10 address unchanged", rb, rdModel(14'h0040));
    bStop();
    chk("R10 no commit", commits - c0, 0);
    chk("R10 no write", wq.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule